// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer with Edge Control

This block is a 16-bit down-counting timer that works in one of four modes, picked by a two-bit field in its control register. Free timer mode counts a prescaled tick. Event mode counts edges of an external input pin. Period mode captures the counter on one chosen edge polarity and then restarts it. High/low pulse mode does the same on every edge of the pin. On underflow the counter reloads from a reload latch and raises a timer interrupt. A separate edge interrupt follows the external pin.

A single edge-select bit shapes each mode in its own way. The edge interrupt and the edge used in period mode share one polarity. Event mode counts the opposite edge. In pulse mode the bit has no effect. A stop bit gates the count source, and reading it back shows whether the counter is running. Software reaches the registers through a small write/read port: control, reload, live count, capture latch, and a sticky flag register that is cleared by writing 1 to a bit.

Top module: `mm_timer`

## Requirements
- R1: After reset the control register reads 0, so the timer runs in free timer mode with edge-select 0. The reload and count registers read 16'hFFFF, and the capture, flag and interrupt outputs are 0.
- R2: In free timer mode (mode field at control bits [5:4] = 2'b00), the counter decrements once per cycle that has tick_i high. A tick that finds the counter at 0 reloads it from the reload latch and pulses irq_tmr_o high for one cycle on the next cycle.
- R3: Control bit 7 set to 1 freezes the count and capture registers, and setting it to 0 resumes counting. Bit 7 reads back as 1 while stopped and as 0 while running.
- R4: A write to the reload register (address 1) while the timer is stopped also loads the counter. While the timer is running, the write changes only the reload latch.
- R5: In event mode (2'b10), tick_i is ignored. The counter decrements on a rising edge of the synchronized pin when control bit 6 = 0, and on a falling edge when bit 6 = 1.
- R6: In period mode (2'b01), a falling edge (bit 6 = 0) or a rising edge (bit 6 = 1) copies the current count into the capture latch (address 3) and restarts the counter from the reload latch. Between those edges, ticks decrement the counter.
- R7: In high/low pulse mode (2'b11), both edges capture and restart the counter, whatever the value of bit 6.
- R8: irq_edge_o pulses for one cycle on a falling pin edge when bit 6 = 0 and on a rising edge when bit 6 = 1. In pulse mode it pulses on both edges. It keeps working while the timer is stopped.
- R9: The pin passes through a two-flop synchronizer. Each pin transition takes effect exactly once, in the third clock edge after the edge that first samples the new level.
- R10: The flag register (address 4) has bit 0 for the timer interrupt and bit 1 for the edge interrupt. A bit is set in the cycle after its pulse and stays set until a write to address 4 has a 1 in that bit. A set that arrives in the same cycle as a clear wins.
- R11: Reads are combinational on addr_i. Address 0 returns the stop, edge-select and mode fields at bits [7:4]. Writes to addresses 2 and 3, and reads from addresses 5 to 7, have no effect and return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled count enable |
| cntr_i | input | 1 | Asynchronous external pin |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| irq_tmr_o | output | 1 | Underflow interrupt pulse |
| irq_edge_o | output | 1 | Pin edge interrupt pulse |

## Verification
A wrong count or capture value shows on rdata_o as soon as the bench reads that address. It also shows as a shifted irq_tmr_o pulse, at the latest one reload period later. A mis-decoded edge polarity or mode first appears as an irq_edge_o pulse on the wrong edge, three cycles after the pin changes. A missing or extra restart then makes the next underflow pulse late or early. A lost flag bit shows on the next read of address 4.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER    = 2'b00,
    MODE_PERIOD   = 2'b01,
    MODE_EVENT    = 2'b10,
    MODE_PULSE_HL = 2'b11
  } mode_e;

  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] A_CTRL   = 3'd0;
  localparam logic [AW-1:0] A_RELOAD = 3'd1;
  localparam logic [AW-1:0] A_COUNT  = 3'd2;
  localparam logic [AW-1:0] A_CAPT   = 3'd3;
  localparam logic [AW-1:0] A_FLAGS  = 3'd4;

  localparam int unsigned N_IRQ    = 2;
  localparam int unsigned IRQ_TMR  = 0;
  localparam int unsigned IRQ_EDGE = 1;
endpackage

// File: rtl/mm_timer_edge.sv
module mm_timer_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= level;
    end
  end

  assign level  = sync_q[STAGES-1];
  assign rise_o = level & ~prev_q;
  assign fall_o = ~level & prev_q;

  assert_single_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  assert_single_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/mm_timer_cnt.sv
module mm_timer_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         cnt_en_i,
  input  logic         restart_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cap_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q, cap_q;
  logic         uf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      cap_q <= '0;
      uf_q  <= 1'b0;
    end else begin
      uf_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
      end else if (run_i) begin
        if (restart_i) begin
          cap_q <= cnt_q;
          cnt_q <= reload_i;
        end else if (cnt_en_i) begin
          if (cnt_q == '0) begin
            cnt_q <= reload_i;
            uf_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
  assign uf_o  = uf_q;

  assert_hold_when_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> ($stable(cnt_q) && $stable(cap_q)));
  assert_uf_from_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_q |-> ($past(cnt_q) == '0 && $past(run_i)));
endmodule

// File: rtl/mm_timer_flags.sv
module mm_timer_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[i] <= 1'b0;
      else if (set_i[i])  flag_q[i] <= 1'b1;
      else if (clr_i[i])  flag_q[i] <= 1'b0;
    end

    assert_flag_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]);
    assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import mm_timer_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cntr_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          irq_tmr_o,
  output logic          irq_edge_o
);
  mode_e        mode_q;
  logic         esel_q, stop_q, irq_edge_q;
  logic [W-1:0] reload_q, cnt, cap;
  logic         rise, fall, uf, sel_edge, ev_edge, cnt_en, restart, load;
  logic [N_IRQ-1:0] flag_set, flag_clr, flags;

  mm_timer_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .pin_i(cntr_i), .rise_o(rise), .fall_o(fall)
  );

  // shared polarity: edge irq and period measure; event counting uses the opposite
  assign sel_edge = esel_q ? rise : fall;
  assign ev_edge  = esel_q ? fall : rise;
  assign cnt_en   = (mode_q == MODE_EVENT) ? ev_edge : tick_i;
  assign restart  = ((mode_q == MODE_PERIOD) && sel_edge) ||
                    ((mode_q == MODE_PULSE_HL) && (rise || fall));
  assign load     = we_i && (addr_i == A_RELOAD) && stop_q;

  mm_timer_cnt #(.W(W)) u_cnt (
    .clk_i, .rst_ni,
    .run_i(!stop_q), .cnt_en_i(cnt_en), .restart_i(restart),
    .load_i(load), .load_val_i(wdata_i), .reload_i(reload_q),
    .cnt_o(cnt), .cap_o(cap), .uf_o(uf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_TIMER;
      esel_q     <= 1'b0;
      stop_q     <= 1'b0;
      reload_q   <= '1;
      irq_edge_q <= 1'b0;
    end else begin
      irq_edge_q <= (mode_q == MODE_PULSE_HL) ? (rise || fall) : sel_edge;
      if (we_i && addr_i == A_CTRL) begin
        mode_q <= mode_e'(wdata_i[5:4]);
        esel_q <= wdata_i[6];
        stop_q <= wdata_i[7];
      end
      if (we_i && addr_i == A_RELOAD) reload_q <= wdata_i;
    end
  end

  always_comb begin
    flag_set           = '0;
    flag_set[IRQ_TMR]  = uf;
    flag_set[IRQ_EDGE] = irq_edge_q;
    flag_clr           = (we_i && addr_i == A_FLAGS) ? wdata_i[N_IRQ-1:0] : '0;
  end

  mm_timer_flags #(.N(N_IRQ)) u_flags (
    .clk_i, .rst_ni, .set_i(flag_set), .clr_i(flag_clr), .flags_o(flags)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:   rdata_o[7:4] = {stop_q, esel_q, mode_q};
      A_RELOAD: rdata_o = reload_q;
      A_COUNT:  rdata_o = cnt;
      A_CAPT:   rdata_o = cap;
      A_FLAGS:  rdata_o[N_IRQ-1:0] = flags;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_tmr_o  = uf;
  assign irq_edge_o = irq_edge_q;

  assert_hl_both_edges_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MODE_PULSE_HL) && (rise || fall)) |=> irq_edge_o);
  assert_event_ignores_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MODE_EVENT) && !ev_edge && !load) |=> $stable(cnt));
endmodule

// File: tb/mm_timer_tb.sv
module mm_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, cntr = 1'b0, we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_tmr, irq_edge;

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  mm_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cntr_i(cntr),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_tmr_o(irq_tmr), .irq_edge_o(irq_edge)
  );

  // behavioural reference
  logic [1:0]  m_mode = 2'd0;
  logic        m_esel = 0, m_stop = 0;
  logic [15:0] m_reload = 16'hFFFF, m_cnt = 16'hFFFF, m_cap = 16'h0;
  logic [1:0]  m_flags = 2'b00;
  logic        m_uf = 0, m_iedge = 0;
  logic        m_s1 = 0, m_s2 = 0, m_prev = 0;

  always @(posedge clk or negedge rst_n) begin
    logic rise, fall, sel, restart, en;
    logic [1:0] clr;
    if (!rst_n) begin
      m_mode = 0; m_esel = 0; m_stop = 0;
      m_reload = 16'hFFFF; m_cnt = 16'hFFFF; m_cap = 0;
      m_flags = 0; m_uf = 0; m_iedge = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      rise = m_s2 && !m_prev;
      fall = !m_s2 && m_prev;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = cntr;
      clr = (we && addr == 3'd4) ? wdata[1:0] : 2'b00;
      m_flags = (m_flags & ~clr) | {m_iedge, m_uf};
      sel = m_esel ? rise : fall;
      m_iedge = (m_mode == 2'd3) ? (rise || fall) : sel;
      m_uf = 0;
      restart = (m_mode == 2'd1 && sel) || (m_mode == 2'd3 && (rise || fall));
      en = (m_mode == 2'd2) ? (m_esel ? fall : rise) : tick;
      if (we && addr == 3'd1 && m_stop) m_cnt = wdata;
      else if (!m_stop) begin
        if (restart) begin m_cap = m_cnt; m_cnt = m_reload; end
        else if (en) begin
          if (m_cnt == 0) begin m_cnt = m_reload; m_uf = 1; end
          else m_cnt = m_cnt - 1;
        end
      end
      if (we && addr == 3'd0) {m_stop, m_esel, m_mode} = wdata[7:4];
      if (we && addr == 3'd1) m_reload = wdata;
    end
  end

  function automatic logic [15:0] exp_rd();
    case (addr)
      3'd0: return {8'h00, m_stop, m_esel, m_mode, 4'h0};
      3'd1: return m_reload;
      3'd2: return m_cnt;
      3'd3: return m_cap;
      3'd4: return {14'h0, m_flags};
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s addr=%0d actual=%h expected=%h at %0t", cur_req, what, addr, act, exp, $time);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("rdata", rdata, exp_rd());
      check("irq_tmr", {15'h0, irq_tmr}, {15'h0, m_uf});
      check("irq_edge", {15'h0, irq_edge}, {15'h0, m_iedge});
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    we = 1; addr = a; wdata = d;
    step();
    we = 0;
  endtask

  task automatic pulse_pin(int hi, int lo);
    cntr = 1; step(hi);
    cntr = 0; step(lo);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all actual=hung expected=finished");
    finish_run();
  end

  initial begin
    cur_req = "R1"; step(3);
    rst_n = 1;
    for (int a = 0; a < 8; a++) begin addr = 3'(a); step(); end

    cur_req = "R4";  // running: reload write leaves counter
    wr(3'd1, 16'd5); addr = 3'd2; step(2);
    wr(3'd0, 16'h0080); wr(3'd1, 16'd4); addr = 3'd2; step(2);
    wr(3'd0, 16'h0000);

    cur_req = "R2";
    addr = 3'd2; tick = 1; step(14);
    for (int i = 0; i < 24; i++) begin tick = (i % 3 == 0); step(); end
    tick = 0; addr = 3'd4; step(2);

    cur_req = "R10";
    wr(3'd4, 16'h0001); addr = 3'd4; step(2);
    wr(3'd4, 16'h0003); step();

    cur_req = "R3";
    tick = 1; wr(3'd0, 16'h0080); addr = 3'd0; step(); addr = 3'd2; step(6);
    wr(3'd0, 16'h0000); addr = 3'd0; step(); addr = 3'd2; step(4);

    cur_req = "R5";
    wr(3'd1, 16'd3); wr(3'd0, 16'h0020); addr = 3'd2;
    for (int i = 0; i < 6; i++) pulse_pin(3, 4);
    wr(3'd0, 16'h0060);
    for (int i = 0; i < 6; i++) pulse_pin(2, 5);
    tick = 0;

    cur_req = "R6";
    wr(3'd1, 16'd100); wr(3'd0, 16'h0010); tick = 1; addr = 3'd3;
    pulse_pin(5, 9); pulse_pin(7, 3); pulse_pin(4, 12);
    wr(3'd0, 16'h0050);
    pulse_pin(6, 6); pulse_pin(11, 2); addr = 3'd2; pulse_pin(3, 8);

    cur_req = "R7";
    wr(3'd0, 16'h0030); addr = 3'd3;
    pulse_pin(5, 8); pulse_pin(2, 6);
    wr(3'd0, 16'h0070);
    pulse_pin(9, 4); pulse_pin(3, 3);

    cur_req = "R8";  // edge irq while stopped
    wr(3'd0, 16'h00C0); pulse_pin(4, 4); wr(3'd0, 16'h0080); pulse_pin(4, 4);

    cur_req = "R9";
    wr(3'd0, 16'h0020); addr = 3'd2;
    pulse_pin(1, 1); pulse_pin(1, 3); pulse_pin(2, 1);

    cur_req = "R11";
    wr(3'd2, 16'h1234); wr(3'd3, 16'h5678);
    for (int a = 0; a < 8; a++) begin addr = 3'(a); step(); end

    cur_req = "R6_R7_R8_R10 mixed";
    wr(3'd0, 16'h0000);
    for (int i = 0; i < 4000; i++) begin
      int r;
      tick = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 4) == 0) cntr = ~cntr;
      addr = 3'($urandom_range(0, 7));
      r = $urandom_range(0, 59);
      if (r == 0)      wr(3'd0, 16'({$urandom_range(0, 1) == 0 ? 1'b0 : 1'b1, 1'($urandom_range(0,1)), 2'($urandom_range(0,3)), 4'h0}));
      else if (r == 1) wr(3'd1, 16'($urandom_range(0, 20)));
      else if (r == 2) wr(3'd4, 16'($urandom_range(0, 3)));
      else if (r == 3) wr(3'd0, 16'($urandom_range(0, 3) << 4));
      else step();
    end
    finish_run();
  end
endmodule